// File: doc/BRIEF.md
# Shared Chip-Select / General-Purpose Pin Port

This block controls four pads that are each used either as an SPI chip-select output or as a general-purpose I/O pin. A per-pin selection mask decides which function a pin has. For a pin in general-purpose use, a 2-bit type field picks one of four drive styles. A port latch holds the value that the pin drives. The block does not model the analog pad. It drives four abstract pad enables per pin: a pull-down, a strong pull-up, a weak pull-up and a very-weak pull-up.

Configuration arrives as single-cycle commands, each with an 8-bit code and an 8-bit operand:

| Code | Action |
|------|--------|
| F4h | Load the port latch |
| F5h | Sample the pins |
| F6h | Load the selection mask |
| F7h | Load the type fields |

Each raw pad input passes through a glitch filter before it is used. The filtered level serves two purposes:
- It is the sensed level that controls the weak pull-up.
- It is the value a sample command places into the byte that goes to buffer position 0.

Each pin has a small burst sequencer with two states, `BS_IDLE` and `BS_BURST`:
- **Start:** `BS_IDLE` goes to `BS_BURST` when a latch write raises a pin's latch bit from 0 to 1 while that pin is in general-purpose, quasi-bidirectional use.
- **Expiry:** `BS_BURST` returns to `BS_IDLE` after `STRONG_CYCLES` clocks.
- **Cancel:** `BS_BURST` also returns to `BS_IDLE` at once if a latch write clears the bit.

Top module: `gpq_port`

## Requirements
- R1: After reset, every pin is in chip-select use, the latch is 0000, every type field is 00, and no burst is active. The sample valid output is 0.
- R2: Command F6h loads the selection mask from operand bits 3:0. Bit n = 1 puts pin n in general-purpose use; bit n = 0 returns it to chip-select use. A pin in chip-select use drives the pull-down when `cs_level[n]` is 0 and the strong pull-up when `cs_level[n]` is 1. Its weak and very-weak pull-ups are off.
- R3: Command F7h loads the type of pin n from operand bits 2n+1:2n. The codes are 00 quasi-bidirectional, 01 push-pull, 10 input-only and 11 open-drain.
- R4: Command F4h loads the latch from operand bits 3:0. Operand bits 7:4 are ignored. The new latch value acts on the pads in the cycle after the command edge.
- R5: In quasi-bidirectional use, the pull-down is on when the latch bit is 0 and the very-weak pull-up is on when the latch bit is 1.
- R6: In quasi-bidirectional use, the weak pull-up is on only when the latch bit is 1 and the filtered pin level is 1.
- R7: In quasi-bidirectional use, a latch write that changes the bit from 0 to 1 turns on the strong pull-up for exactly `STRONG_CYCLES` (default 2) cycles, starting the cycle after the command edge. A write that clears the bit ends the burst at once. A 1-to-1 write starts no burst.
- R8: In push-pull use, the strong pull-up is on whenever the latch bit is 1 and the pull-down is on whenever it is 0.
- R9: In open-drain use, every pull-up is off and the pull-down is on only when the latch bit is 0.
- R10: In input-only use, all four pad enables are off.
- R11: The filtered level takes a new pad value only after that value has been seen at `FILT_CYCLES`+1 consecutive clock edges (2 by default). It changes at the last of those edges. A pulse that lasts a single clock is rejected.
- R12: Command F5h raises `smp_valid` for one cycle after the command edge. `smp_byte` then holds the filtered levels ANDed with the selection mask in bits 3:0, with bits 7:4 at 0. Bits for pins in chip-select use therefore read 0.
- R13: Any other command code changes neither the latch, the mask nor the type fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code (F4h, F5h, F6h, F7h) |
| cmd_data | input | 8 | Command operand |
| cs_level | input | 4 | Chip-select level from the SPI engine, per pin |
| pad_in | input | 4 | Raw pad input levels |
| pad_pd | output | 4 | Pull-down enable per pin |
| pad_pu_strong | output | 4 | Strong pull-up enable per pin |
| pad_pu_weak | output | 4 | Weak pull-up enable per pin |
| pad_pu_vweak | output | 4 | Very-weak pull-up enable per pin |
| smp_valid | output | 1 | Sample byte valid for buffer position 0 |
| smp_byte | output | 8 | Sampled pin byte |

## Verification
The assertions check, on every cycle:
- no pin enables a pull-down together with any pull-up;
- open-drain and input-only pins stay quiet on the pull-ups;
- the weak pull-up never comes on without a latched 1 and a sensed 1;
- a burst begins only right after a 0-to-1 latch write;
- the filtered level only takes a value that the raw input held at the two preceding edges;
- the latch and the mask change only on their own commands.

Some behaviours depend on a history of events, and only the bench's scenarios show them:
- the exact two-cycle burst length, and its cancellation;
- the rejection of a one-clock glitch;
- the read-back values after the selection mask changes;
- the absence of any effect from an unknown code.

// File: rtl/gpq_pkg.sv
package gpq_pkg;

    typedef enum logic [1:0] {
        PM_QUASI     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_INPUT     = 2'b10,
        PM_OPENDRAIN = 2'b11
    } pin_mode_e;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_BURST = 1'b1
    } burst_state_e;

    typedef struct packed {
        logic pull_down;
        logic pu_strong;
        logic pu_weak;
        logic pu_vweak;
    } pad_ctl_t;

    localparam logic [7:0] CMD_PORT_WRITE  = 8'hF4;
    localparam logic [7:0] CMD_PORT_SAMPLE = 8'hF5;
    localparam logic [7:0] CMD_FUNC_SELECT = 8'hF6;
    localparam logic [7:0] CMD_PIN_TYPE    = 8'hF7;

endpackage

// File: rtl/gpq_glitch_filter.sv
module gpq_glitch_filter #(
    parameter int FILT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

    logic          samp_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            level  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            samp_q <= raw;
            if (raw != level && raw == samp_q) begin
                if (cnt_q == CW'(FILT_CYCLES - 1)) begin
                    level <= raw;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_FILTER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (level == $past(raw) && level == $past(raw, 2))); // R11

endmodule

// File: rtl/gpq_pin_driver.sv
module gpq_pin_driver
    import gpq_pkg::*;
#(
    parameter int STRONG_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gpio_sel,
    input  pin_mode_e mode,
    input  logic      latch_q,
    input  logic      latch_d,
    input  logic      latch_wr,
    input  logic      sense,
    input  logic      cs_level,
    output pad_ctl_t  ctl
);
    localparam int SW = (STRONG_CYCLES > 1) ? $clog2(STRONG_CYCLES) : 1;

    burst_state_e  st_q, st_d;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          start;

    assign start = latch_wr && gpio_sel && (mode == PM_QUASI) && !latch_q && latch_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BS_IDLE: begin
                if (start) begin
                    st_d  = BS_BURST;
                    cnt_d = '0;
                end
            end
            BS_BURST: begin
                if (latch_wr && !latch_d) begin
                    st_d = BS_IDLE;
                end else if (cnt_q == SW'(STRONG_CYCLES - 1)) begin
                    st_d = BS_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = BS_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        if (!gpio_sel) begin
            ctl.pull_down = !cs_level;
            ctl.pu_strong = cs_level;
        end else begin
            unique case (mode)
                PM_QUASI: begin
                    ctl.pull_down = !latch_q;
                    ctl.pu_vweak  = latch_q;
                    ctl.pu_weak   = latch_q && sense;
                    ctl.pu_strong = latch_q && (st_q == BS_BURST);
                end
                PM_PUSHPULL: begin
                    ctl.pull_down = !latch_q;
                    ctl.pu_strong = latch_q;
                end
                PM_INPUT: begin
                    ctl = '0;
                end
                PM_OPENDRAIN: begin
                    ctl.pull_down = !latch_q;
                end
            endcase
        end
    end

    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pull_down |-> !(ctl.pu_strong || ctl.pu_weak || ctl.pu_vweak)); // R5
    AST_WEAK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pu_weak |-> (sense && latch_q && ctl.pu_vweak)); // R6
    AST_BURST_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == BS_BURST) |-> ($past(latch_wr) && latch_q && !$past(latch_q))); // R7
    AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_sel && mode == PM_OPENDRAIN) |-> !(ctl.pu_strong || ctl.pu_weak || ctl.pu_vweak)); // R9
    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_sel && mode == PM_INPUT) |-> (ctl == '0)); // R10

endmodule

// File: rtl/gpq_port.sv
module gpq_port
    import gpq_pkg::*;
#(
    parameter int PINS          = 4,
    parameter int FILT_CYCLES   = 1,
    parameter int STRONG_CYCLES = 2,
    parameter int BYTE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic [PINS-1:0]   cs_level,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_pd,
    output logic [PINS-1:0]   pad_pu_strong,
    output logic [PINS-1:0]   pad_pu_weak,
    output logic [PINS-1:0]   pad_pu_vweak,
    output logic              smp_valid,
    output logic [BYTE_W-1:0] smp_byte
);
    localparam int TYPE_W = 2;
    localparam int CFG_W  = TYPE_W * PINS;

    logic [PINS-1:0]  sel_q;
    logic [PINS-1:0]  latch_q;
    logic [CFG_W-1:0] type_q;
    logic [PINS-1:0]  filt_lvl;
    logic             latch_wr;
    logic [PINS-1:0]  latch_d;
    pad_ctl_t         drv_ctl [PINS];

    assign latch_wr = cmd_valid && (cmd_code == CMD_PORT_WRITE);
    assign latch_d  = cmd_data[PINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            latch_q   <= '0;
            type_q    <= '0;
            smp_valid <= 1'b0;
            smp_byte  <= '0;
        end else begin
            smp_valid <= 1'b0;
            if (cmd_valid) begin
                case (cmd_code)
                    CMD_PORT_WRITE:  latch_q <= latch_d;
                    CMD_FUNC_SELECT: sel_q   <= cmd_data[PINS-1:0];
                    CMD_PIN_TYPE:    type_q  <= cmd_data[CFG_W-1:0];
                    CMD_PORT_SAMPLE: begin
                        smp_valid <= 1'b1;
                        smp_byte  <= BYTE_W'(filt_lvl & sel_q);
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpq_glitch_filter #(
            .FILT_CYCLES (FILT_CYCLES)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pad_in[i]),
            .level (filt_lvl[i])
        );

        gpq_pin_driver #(
            .STRONG_CYCLES (STRONG_CYCLES)
        ) u_drv (
            .clk      (clk),
            .rst_n    (rst_n),
            .gpio_sel (sel_q[i]),
            .mode     (pin_mode_e'(type_q[TYPE_W*i +: TYPE_W])),
            .latch_q  (latch_q[i]),
            .latch_d  (latch_d[i]),
            .latch_wr (latch_wr),
            .sense    (filt_lvl[i]),
            .cs_level (cs_level[i]),
            .ctl      (drv_ctl[i])
        );

        assign pad_pd[i]        = drv_ctl[i].pull_down;
        assign pad_pu_strong[i] = drv_ctl[i].pu_strong;
        assign pad_pu_weak[i]   = drv_ctl[i].pu_weak;
        assign pad_pu_vweak[i]  = drv_ctl[i].pu_vweak;
    end

    AST_SAMPLE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(cmd_valid && cmd_code == CMD_PORT_SAMPLE)); // R12
    AST_SAMPLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((smp_byte & ~BYTE_W'(sel_q)) == '0)); // R12
    AST_LATCH_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> $past(latch_wr)); // R4
    AST_SEL_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(cmd_valid && cmd_code == CMD_FUNC_SELECT)); // R13

endmodule

// File: tb/gpq_port_tb.sv
module gpq_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [7:0] cmd_data = 8'h00;
    logic [3:0] cs_level = 4'b1111;
    logic [3:0] pad_in = 4'b0000;
    logic [3:0] pad_pd, pad_pu_strong, pad_pu_weak, pad_pu_vweak;
    logic       smp_valid;
    logic [7:0] smp_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    gpq_port u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .cs_level(cs_level), .pad_in(pad_in),
        .pad_pd(pad_pd), .pad_pu_strong(pad_pu_strong), .pad_pu_weak(pad_pu_weak),
        .pad_pu_vweak(pad_pu_vweak), .smp_valid(smp_valid), .smp_byte(smp_byte)
    );

    // Reference model state
    bit [3:0] m_en, m_latch, m_filt, m_last;
    bit [1:0] m_cfg [4];
    int       m_run [4];
    int       m_rem [4];
    bit       m_rdv;
    bit [7:0] m_rdb;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [3:0] exp_ctl(input int n);
        bit l;
        l = m_latch[n];
        if (!m_en[n]) return {!cs_level[n], cs_level[n], 1'b0, 1'b0};
        case (m_cfg[n])
            2'b00:   return {!l, l && (m_rem[n] > 0), l && m_filt[n], l};
            2'b01:   return {!l, l, 1'b0, 1'b0};
            2'b10:   return 4'b0000;
            default: return {!l, 1'b0, 1'b0, 1'b0};
        endcase
    endfunction

    function automatic string tag_of(input int n);
        if (!m_en[n]) return "R2 chip-select pin";
        case (m_cfg[n])
            2'b00:   return "R5 R6 R7 quasi pin";
            2'b01:   return "R8 push-pull pin";
            2'b10:   return "R10 input-only pin";
            default: return "R9 open-drain pin";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_latch = 0; m_filt = 0; m_last = 0; m_rdv = 0; m_rdb = 0;
            for (int n = 0; n < 4; n++) begin m_cfg[n] = 0; m_run[n] = 1; m_rem[n] = 0; end
        end else begin
            m_rdv = 0;
            if (cmd_valid && cmd_code == 8'hF5) begin
                m_rdv = 1;
                m_rdb = {4'b0000, m_filt & m_en};
            end
            for (int n = 0; n < 4; n++) begin
                if (pad_in[n] == m_last[n]) m_run[n]++; else m_run[n] = 1;
                m_last[n] = pad_in[n];
                if (m_run[n] >= 2 && pad_in[n] != m_filt[n]) m_filt[n] = pad_in[n];
                if (m_rem[n] > 0) m_rem[n]--;
            end
            if (cmd_valid) begin
                case (cmd_code)
                    8'hF4: for (int n = 0; n < 4; n++) begin
                        if (cmd_data[n] && !m_latch[n] && m_en[n] && m_cfg[n] == 2'b00) m_rem[n] = 2;
                        if (!cmd_data[n]) m_rem[n] = 0;
                        m_latch[n] = cmd_data[n];
                    end
                    8'hF6: m_en = cmd_data[3:0];
                    8'hF7: for (int n = 0; n < 4; n++) m_cfg[n] = cmd_data[2*n +: 2];
                    default: ;
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int n = 0; n < 4; n++) begin
                bit [3:0] e;
                logic [3:0] a;
                e = exp_ctl(n);
                a = {pad_pd[n], pad_pu_strong[n], pad_pu_weak[n], pad_pu_vweak[n]};
                chk(a === e, tag_of(n), {4'b0, a}, {4'b0, e});
            end
            chk(smp_valid === m_rdv, "R12 sample valid", {7'b0, smp_valid}, {7'b0, m_rdv});
            if (m_rdv) chk(smp_byte === m_rdb, "R12 sample byte", smp_byte, m_rdb);
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic send(input logic [7:0] c, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_code = c; cmd_data = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00; cmd_data = 8'h00;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pads(input logic [3:0] pd, input logic [3:0] st, input logic [3:0] wk,
                        input logic [3:0] vw, input string tag);
        chk(pad_pd === pd, tag, {4'b0, pad_pd}, {4'b0, pd});
        chk(pad_pu_strong === st, tag, {4'b0, pad_pu_strong}, {4'b0, st});
        chk(pad_pu_weak === wk, tag, {4'b0, pad_pu_weak}, {4'b0, wk});
        chk(pad_pu_vweak === vw, tag, {4'b0, pad_pu_vweak}, {4'b0, vw});
    endtask

    task automatic sample(input logic [7:0] exp, input string tag);
        send(8'hF5, 8'h00);
        chk(smp_valid === 1'b1, tag, {7'b0, smp_valid}, 8'h01);
        chk(smp_byte === exp, tag, smp_byte, exp);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        pads(4'b0000, 4'b1111, 4'b0000, 4'b0000, "R1 reset chip-select");
        chk(smp_valid === 1'b0, "R1 reset sample valid", {7'b0, smp_valid}, 8'h00);

        send(8'hF6, 8'h0F);
        pads(4'b1111, 4'b0000, 4'b0000, 4'b0000, "R2 all pins general-purpose");

        send(8'hF4, 8'hA5);                       // R4: upper nibble ignored
        pads(4'b1010, 4'b0101, 4'b0000, 4'b0101, "R4 R7 latch write, burst cycle 1");
        idle(1);
        chk(pad_pu_strong === 4'b0101, "R7 burst cycle 2", {4'b0, pad_pu_strong}, 8'h05);
        idle(1);
        chk(pad_pu_strong === 4'b0000, "R7 burst ended", {4'b0, pad_pu_strong}, 8'h00);

        pad_in = 4'b0101;
        idle(2);
        chk(pad_pu_weak === 4'b0101, "R6 weak with sensed high", {4'b0, pad_pu_weak}, 8'h05);

        send(8'hF7, 8'hE4);                       // R3: pin0 quasi, pin1 pp, pin2 input, pin3 od
        pads(4'b1010, 4'b0000, 4'b0001, 4'b0001, "R3 mixed types");
        send(8'hF4, 8'h0F);
        pads(4'b0000, 4'b0010, 4'b0001, 4'b0001, "R8 R9 R10 latch all ones");

        pad_in = 4'b1101;
        idle(1);
        pad_in = 4'b0101;
        idle(2);
        sample(8'h05, "R11 one-clock glitch rejected");
        idle(1);
        chk(smp_valid === 1'b0, "R12 sample valid one cycle", {7'b0, smp_valid}, 8'h00);

        pad_in = 4'b1101;
        idle(2);
        sample(8'h0D, "R11 stable level accepted");

        cs_level = 4'b0110;
        send(8'hF6, 8'h03);
        pads(4'b1000, 4'b0110, 4'b0001, 4'b0001, "R2 pins back to chip-select");
        sample(8'h01, "R12 chip-select bits read zero");

        send(8'h33, 8'hFF);
        pads(4'b1000, 4'b0110, 4'b0001, 4'b0001, "R13 unknown code ignored");
        sample(8'h01, "R13 mask unchanged");

        send(8'hF6, 8'h0F);
        send(8'hF7, 8'h00);
        send(8'hF4, 8'h00);
        send(8'hF4, 8'h01);
        chk(pad_pu_strong[0] === 1'b1, "R7 burst started", {7'b0, pad_pu_strong[0]}, 8'h01);
        send(8'hF4, 8'h00);
        chk(pad_pu_strong[0] === 1'b0, "R7 burst cancelled", {7'b0, pad_pu_strong[0]}, 8'h00);
        chk(pad_pd[0] === 1'b1, "R5 pull-down with latch 0", {7'b0, pad_pd[0]}, 8'h01);
        idle(3);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule